// File: doc/BRIEF.md
# Configuration Port FIFO Bridge

This block sits between a processor's memory-mapped bus and an internal configuration port. Software loads 32-bit words into a write queue, then sets a start bit; a transfer engine hands those words to the port one at a time under a valid/ready handshake. For the opposite direction, software programs a word count and sets a second start bit; the engine requests that many words from the port and stores them in a read queue, from which software pops them one per bus read.

Software never drives the port itself. It watches a busy indication in the control register, a done flag in the status register, the free space left in the write queue and the fill level of the read queue. A completion event is latched into an interrupt status bit, which raises an interrupt line when both the per-source enable and the global enable are on.

The engine is a three-state machine. `ENG_IDLE` waits for a start request. From there, transition *launch-out* enters `ENG_PUSH_OUT` when the write start bit is set, and transition *launch-in* enters `ENG_PULL_IN` when only the read start bit is set. Transition *drained* leaves `ENG_PUSH_OUT` for `ENG_IDLE` in a cycle that begins with an empty write queue. Transition *counted* leaves `ENG_PULL_IN` for `ENG_IDLE` in a cycle that begins with no words left to fetch.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset the status register (0x110) reads 1, vacancy (0x114) reads DEPTH, occupancy (0x118) reads 0, control (0x10C) reads 0, `irq` is 0, and neither `cfg_wr_valid` nor `cfg_rd_req` is asserted.
- R2: A bus write to 0x100 appends `bus_wdata` to the write queue, and 0x114 reads DEPTH minus the number of words held. A write to 0x100 while the queue holds DEPTH words is dropped and leaves it unchanged.
- R3: In `ENG_PUSH_OUT`, `cfg_wr_valid` is high while the write queue holds words, and `cfg_wdata` is the oldest word. A word is consumed on each clock edge where `cfg_wr_valid` and `cfg_ready` are both high. While `cfg_ready` is low, the word is held stable. Words leave in the order they were written.
- R4: Writing a 1 to control bit 0 while idle starts a write transfer. Control bit 0 reads 1 from the next cycle on. It reads 0 again from the cycle after a cycle that began with the write queue empty.
- R5: Writing 1 to control bit 1 alone while idle starts a readback of the word count held at 0x108. `cfg_rd_req` is high while words remain and the read queue holds fewer than DEPTH words. Each edge with `cfg_rd_req` and `cfg_ready` high stores `cfg_rdata` and lowers the remaining count. Control bit 1 reads 1 until the count reaches 0. A count of 0 finishes after one busy cycle.
- R6: A bus read of 0x104 returns the oldest read-queue word and removes it. On an empty queue it returns 0 and changes nothing. 0x118 reads the number of words held.
- R7: A control write with both bits 0 and 1 set starts a write transfer only. No readback takes place.
- R8: Status bit 0 falls on the edge that starts a transfer and rises on the edge that returns the engine to `ENG_IDLE`.
- R9: Control writes made while a transfer runs are ignored.
- R10: Interrupt status bit 0 (0x20) is set when a transfer finishes and cleared by writing 1 to it; a finish in the same cycle wins. Enable bit 0 (0x28) and global enable bit 31 (0x1C) are read/write. `irq` is the AND of the three bits.
- R11: 0x108 reads back the last value written. Reads of 0x100 and of any unlisted offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Bus write strobe, one word per cycle |
| bus_rd | input | 1 | Bus read strobe; pops the read queue at 0x104 |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data, combinational from `bus_addr` |
| cfg_wr_valid | output | 1 | Word offered to the configuration port |
| cfg_wdata | output | DATA_W | Word offered to the port |
| cfg_rd_req | output | 1 | Request for one readback word |
| cfg_rdata | input | DATA_W | Readback word from the port |
| cfg_ready | input | 1 | Port accepts or delivers a word this cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions rely on the bus and the port changing only between clock edges. They also rely on the port keeping `cfg_ready` meaningful in every cycle, although it may stay low for any number of cycles. The bench drives every input on the falling edge and sweeps `cfg_ready` through four patterns: never ready, always ready, alternating, and two cycles out of three. This keeps the stall and handshake properties inside their assumed timing while still stalling the port in both directions. The read queue is filled to its limit during a long readback, so that the flow-control rule on `cfg_rd_req` is tested at its edge.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE     = 2'd0,
        ENG_PUSH_OUT = 2'd1,
        ENG_PULL_IN  = 2'd2
    } eng_state_e;

    // register byte offsets (software-visible map)
    localparam int OFS_GIE   = 'h01C;
    localparam int OFS_ISR   = 'h020;
    localparam int OFS_IER   = 'h028;
    localparam int OFS_WQ    = 'h100;
    localparam int OFS_RQ    = 'h104;
    localparam int OFS_SIZE  = 'h108;
    localparam int OFS_CTRL  = 'h10C;
    localparam int OFS_STAT  = 'h110;
    localparam int OFS_VAC   = 'h114;
    localparam int OFS_OCC   = 'h118;

endpackage

// File: rtl/cfgx_fifo.sv
module cfgx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop  && (count != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cfgx_engine.sv
module cfgx_engine
    import cfgx_pkg::*;
#(
    parameter int SIZE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_out,
    input  logic              req_in,
    input  logic [SIZE_W-1:0] size,
    input  logic              wq_empty,
    input  logic              rq_full,
    input  logic              port_ready,
    output eng_state_e        state,
    output logic              wq_pop,
    output logic              rq_push,
    output logic              port_wr,
    output logic              port_rd,
    output logic              done,
    output logic              finish
);

    eng_state_e        state_d;
    logic [SIZE_W-1:0] remain_q;

    // next-state selection: out-going request outranks the readback request
    always_comb begin
        state_d = state;
        unique case (state)
            ENG_IDLE: begin
                if (req_out)     state_d = ENG_PUSH_OUT;   // launch-out
                else if (req_in) state_d = ENG_PULL_IN;    // launch-in
            end
            ENG_PUSH_OUT: begin
                if (wq_empty)    state_d = ENG_IDLE;       // drained
            end
            ENG_PULL_IN: begin
                if (remain_q == '0) state_d = ENG_IDLE;    // counted
            end
            default:             state_d = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_d;
    end

    // outputs
    always_comb begin
        port_wr = 1'b0;
        port_rd = 1'b0;
        unique case (state)
            ENG_PUSH_OUT: port_wr = !wq_empty;
            ENG_PULL_IN:  port_rd = (remain_q != '0) && !rq_full;
            default: begin
                port_wr = 1'b0;
                port_rd = 1'b0;
            end
        endcase
        wq_pop  = port_wr && port_ready;
        rq_push = port_rd && port_ready;
        finish  = (state != ENG_IDLE) && (state_d == ENG_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            done     <= 1'b1;
        end else begin
            if (state == ENG_IDLE && state_d == ENG_PULL_IN) remain_q <= size;
            else if (rq_push)                                 remain_q <= remain_q - SIZE_W'(1);
            if (state == ENG_IDLE && state_d != ENG_IDLE)     done <= 1'b0;
            else if (finish)                                  done <= 1'b1;
        end
    end

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
    import cfgx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cfg_wr_valid,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_rd_req,
    input  logic [DATA_W-1:0] cfg_rdata,
    input  logic              cfg_ready,
    output logic              irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    eng_state_e        eng_state;
    logic              wq_pop, rq_push, eng_done, eng_finish;
    logic [CNT_W-1:0]  wq_count, rq_count;
    logic [DATA_W-1:0] rq_head;
    logic [DATA_W-1:0] size_q;
    logic              gie_q, ier_q, isr_q;
    logic              ctrl_hit, wq_push, rq_pop;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wq_push  = bus_wr && at(bus_addr, OFS_WQ);
    assign rq_pop   = bus_rd && at(bus_addr, OFS_RQ) && (rq_count != '0);
    assign ctrl_hit = bus_wr && at(bus_addr, OFS_CTRL);

    cfgx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_wq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wq_push),
        .wdata (bus_wdata),
        .pop   (wq_pop),
        .head  (cfg_wdata),
        .count (wq_count)
    );

    cfgx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rq_push),
        .wdata (cfg_rdata),
        .pop   (rq_pop),
        .head  (rq_head),
        .count (rq_count)
    );

    cfgx_engine #(.SIZE_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_out    (ctrl_hit && bus_wdata[0]),
        .req_in     (ctrl_hit && bus_wdata[1]),
        .size       (size_q),
        .wq_empty   (wq_count == '0),
        .rq_full    (rq_count == CNT_W'(DEPTH)),
        .port_ready (cfg_ready),
        .state      (eng_state),
        .wq_pop     (wq_pop),
        .rq_push    (rq_push),
        .port_wr    (cfg_wr_valid),
        .port_rd    (cfg_rd_req),
        .done       (eng_done),
        .finish     (eng_finish)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            gie_q  <= 1'b0;
            ier_q  <= 1'b0;
            isr_q  <= 1'b0;
        end else begin
            if (bus_wr && at(bus_addr, OFS_SIZE)) size_q <= bus_wdata;
            if (bus_wr && at(bus_addr, OFS_GIE))  gie_q  <= bus_wdata[DATA_W-1];
            if (bus_wr && at(bus_addr, OFS_IER))  ier_q  <= bus_wdata[0];
            if (eng_finish)                                        isr_q <= 1'b1;
            else if (bus_wr && at(bus_addr, OFS_ISR) && bus_wdata[0]) isr_q <= 1'b0;
        end
    end

    assign irq = gie_q && ier_q && isr_q;

    always_comb begin
        bus_rdata = '0;
        if (at(bus_addr, OFS_RQ))
            bus_rdata = (rq_count != '0) ? rq_head : '0;
        else if (at(bus_addr, OFS_SIZE))
            bus_rdata = size_q;
        else if (at(bus_addr, OFS_CTRL))
            bus_rdata = {{(DATA_W-2){1'b0}}, eng_state == ENG_PULL_IN, eng_state == ENG_PUSH_OUT};
        else if (at(bus_addr, OFS_STAT))
            bus_rdata = {{(DATA_W-1){1'b0}}, eng_done};
        else if (at(bus_addr, OFS_VAC))
            bus_rdata = DATA_W'(DEPTH) - DATA_W'(wq_count);
        else if (at(bus_addr, OFS_OCC))
            bus_rdata = DATA_W'(rq_count);
        else if (at(bus_addr, OFS_GIE))
            bus_rdata = {gie_q, {(DATA_W-1){1'b0}}};
        else if (at(bus_addr, OFS_ISR))
            bus_rdata = {{(DATA_W-1){1'b0}}, isr_q};
        else if (at(bus_addr, OFS_IER))
            bus_rdata = {{(DATA_W-1){1'b0}}, ier_q};
    end

endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5,
    parameter int DW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          port_wr,
    input logic          port_rd,
    input logic          port_ready,
    input logic [DW-1:0] port_wdata,
    input logic          done,
    input logic          isr,
    input logic [CW-1:0] rcount,
    input logic [CW-1:0] wcount
);

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr && !port_ready |=> port_wr && $stable(port_wdata));

    // R7
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr && port_rd));

    // R8
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr || port_rd) |-> !done);

    // R10
    fin_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> isr);

    // R5
    rd_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |-> rcount < CW'(DEPTH));

    // R2
    wq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wcount <= CW'(DEPTH));

endmodule

bind cfgport_bridge cfgx_chk #(.DEPTH(DEPTH), .CW(CNT_W), .DW(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_wr    (cfg_wr_valid),
    .port_rd    (cfg_rd_req),
    .port_ready (cfg_ready),
    .port_wdata (cfg_wdata),
    .done       (eng_done),
    .isr        (isr_q),
    .rcount     (rq_count),
    .wcount     (wq_count)
);

// File: tb/sim_cfgport_bridge.sv
module sim_cfgport_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = 9'h110;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          cfg_wr_valid, cfg_rd_req, irq;
    logic [31:0]   cfg_wdata, cfg_rdata;
    logic          cfg_ready = 1'b0;

    int checks = 0, fails = 0, cyc = 0, ready_mode = 0;

    // reference model state
    int          m_st;
    logic [31:0] wq[$], rq[$], plog[$];
    logic [31:0] m_size, m_rem, rb_cnt;
    bit          m_done, m_isr, m_ier, m_gie;

    cfgport_bridge #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wdata(cfg_wdata),
        .cfg_rd_req(cfg_rd_req), .cfg_rdata(cfg_rdata),
        .cfg_ready(cfg_ready), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    assign cfg_rdata = 32'hA500_0000 | rb_cnt;

    function automatic bit exp_rd_req();
        return m_st == 2 && m_rem != 0 && rq.size() < DEPTH;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [AW-1:0] a);
        case (a)
            9'h104: return (rq.size() > 0) ? rq[0] : 32'h0;
            9'h108: return m_size;
            9'h10C: return {30'h0, m_st == 2, m_st == 1};
            9'h110: return {31'h0, m_done};
            9'h114: return DEPTH - wq.size();
            9'h118: return rq.size();
            9'h01C: return {m_gie, 31'h0};
            9'h020: return {31'h0, m_isr};
            9'h028: return {31'h0, m_ier};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // model update on the same edge the design updates
    always @(posedge clk) begin
        bit hw, hr, wfp, rfp, was_empty, was_zero, fin;
        if (!rst_n) begin
            m_st = 0; wq.delete(); rq.delete(); plog.delete();
            m_size = 0; m_rem = 0; m_done = 1; m_isr = 0; m_ier = 0; m_gie = 0;
            rb_cnt <= 0;
        end else begin
            hw  = m_st == 1 && wq.size() > 0 && cfg_ready;
            hr  = exp_rd_req() && cfg_ready;
            was_empty = wq.size() == 0;
            was_zero  = m_rem == 0;
            wfp = bus_wr && bus_addr == 9'h100 && wq.size() < DEPTH;
            rfp = bus_rd && bus_addr == 9'h104 && rq.size() > 0;
            fin = 0;
            if (hw)  plog.push_back(wq.pop_front());
            if (wfp) wq.push_back(bus_wdata);
            if (rfp) void'(rq.pop_front());
            if (hr) begin
                rq.push_back(cfg_rdata);
                m_rem = m_rem - 1;
                rb_cnt <= rb_cnt + 1;
            end
            case (m_st)
                0: if (bus_wr && bus_addr == 9'h10C) begin
                       if (bus_wdata[0])      begin m_st = 1; m_done = 0; end
                       else if (bus_wdata[1]) begin m_st = 2; m_rem = m_size; m_done = 0; end
                   end
                1: if (was_empty) begin m_st = 0; fin = 1; end
                default: if (was_zero) begin m_st = 0; fin = 1; end
            endcase
            if (fin) m_done = 1;
            if (bus_wr && bus_addr == 9'h108) m_size = bus_wdata;
            if (bus_wr && bus_addr == 9'h01C) m_gie  = bus_wdata[31];
            if (bus_wr && bus_addr == 9'h028) m_ier  = bus_wdata[0];
            if (fin) m_isr = 1;
            else if (bus_wr && bus_addr == 9'h020 && bus_wdata[0]) m_isr = 0;
        end
    end

    // port stimulus and per-cycle comparison
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0: cfg_ready = 1'b0;
            1: cfg_ready = 1'b1;
            2: cfg_ready = cyc[0];
            default: cfg_ready = (cyc % 3) != 0;
        endcase
        #2;
        if (rst_n) begin
            chk("R3 wr_valid", {31'h0, cfg_wr_valid}, {31'h0, m_st == 1 && wq.size() > 0});
            if (cfg_wr_valid) chk("R3 wdata", cfg_wdata, wq[0]);
            chk("R5 rd_req", {31'h0, cfg_rd_req}, {31'h0, exp_rd_req()});
            chk("R6 bus_rdata", bus_rdata, exp_rdata(bus_addr));
            chk("R10 irq", {31'h0, irq}, {31'h0, m_gie && m_ier && m_isr});
        end
    end

    task automatic bwrite(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 9'h110;
    endtask

    task automatic bread(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #3 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 9'h110;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && m_st != 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d, base;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bread(9'h110, d); chk("R1 status", d, 1);
        bread(9'h114, d); chk("R1 vacancy", d, DEPTH);
        bread(9'h118, d); chk("R1 occupancy", d, 0);
        bread(9'h10C, d); chk("R1 control", d, 0);
        chk("R1 irq", {31'h0, irq}, 0);
        chk("R1 strobes", {30'h0, cfg_wr_valid, cfg_rd_req}, 0);

        // R2 R3 R4 write transfer, alternating ready
        ready_mode = 2;
        for (int i = 0; i < 3; i++) bwrite(9'h100, 32'hB000_0000 + i);
        bread(9'h114, d); chk("R2 vacancy", d, DEPTH - 3);
        bwrite(9'h10C, 1);
        bread(9'h10C, d); chk("R4 busy bit", d, 1);
        bread(9'h110, d); chk("R8 done low", d, 0);
        wait_idle();
        bread(9'h10C, d); chk("R4 bit cleared", d, 0);
        bread(9'h110, d); chk("R8 done high", d, 1);
        chk("R3 count", plog.size(), 3);
        for (int i = 0; i < 3; i++) chk("R3 order", plog[i], 32'hB000_0000 + i);

        // R2 overflow dropped
        for (int i = 0; i < DEPTH + 2; i++) bwrite(9'h100, 32'hC000_0000 + i);
        bread(9'h114, d); chk("R2 full vacancy", d, 0);
        ready_mode = 1;
        bwrite(9'h10C, 1);
        wait_idle();
        chk("R2 dropped", plog.size(), 3 + DEPTH);
        chk("R2 last kept", plog[plog.size()-1], 32'hC000_0000 + DEPTH - 1);

        // R5 R6 readback of five words, 2-of-3 ready
        ready_mode = 3;
        base = rb_cnt;
        bwrite(9'h108, 5);
        bwrite(9'h10C, 2);
        wait_idle();
        bread(9'h118, d); chk("R5 occupancy", d, 5);
        for (int i = 0; i < 5; i++) begin
            bread(9'h104, d); chk("R6 pop", d, 32'hA500_0000 | (base + i));
        end
        bread(9'h104, d); chk("R6 empty read", d, 0);
        bread(9'h118, d); chk("R6 empty occ", d, 0);

        // R5 read queue full stalls the port
        ready_mode = 1;
        bwrite(9'h108, DEPTH + 3);
        bwrite(9'h10C, 2);
        repeat (40) @(negedge clk);
        bread(9'h118, d); chk("R5 stalled occ", d, DEPTH);
        bread(9'h10C, d); chk("R5 still busy", d, 2);
        for (int i = 0; i < 3; i++) bread(9'h104, d);
        wait_idle();
        bread(9'h118, d); chk("R5 final occ", d, DEPTH);
        n = DEPTH;
        for (int i = 0; i < n; i++) bread(9'h104, d);

        // R7 both start bits: write wins
        bwrite(9'h100, 32'hD00D_0001);
        bwrite(9'h108, 4);
        ready_mode = 0;
        bwrite(9'h10C, 3);
        bread(9'h10C, d); chk("R7 write only", d, 1);
        // R9 control write while busy ignored
        bwrite(9'h10C, 2);
        bread(9'h10C, d); chk("R9 ignored", d, 1);
        ready_mode = 1;
        wait_idle();
        bread(9'h118, d); chk("R7 R9 no readback", d, 0);
        chk("R7 word sent", plog[plog.size()-1], 32'hD00D_0001);

        // R10 interrupt path, R5 zero-length readback
        bwrite(9'h020, 1);
        bread(9'h020, d); chk("R10 isr cleared", d, 0);
        bwrite(9'h01C, 32'h8000_0000);
        bwrite(9'h028, 1);
        chk("R10 irq idle", {31'h0, irq}, 0);
        bwrite(9'h108, 0);
        bwrite(9'h10C, 2);
        wait_idle();
        bread(9'h110, d); chk("R5 zero size done", d, 1);
        chk("R10 irq raised", {31'h0, irq}, 1);
        bwrite(9'h020, 1);
        chk("R10 irq cleared", {31'h0, irq}, 0);
        bread(9'h01C, d); chk("R10 gie", d, 32'h8000_0000);

        // R11 unmapped and size readback
        bread(9'h0FC, d); chk("R11 unmapped", d, 0);
        bread(9'h100, d); chk("R11 wq read", d, 0);
        bwrite(9'h108, 7);
        bread(9'h108, d); chk("R11 size", d, 7);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule